// File: doc/BRIEF.md
# Multicycle Core Exception Detector

This block sits beside a small five-step multicycle processor and watches its control step, program counter and the opcode field of its instruction register. It flags two faults. An opcode outside the supported set that reaches the execute step is an illegal-instruction fault. A fetch whose word index (PC shifted right by two) lands in the data half of the shared 32-word memory is a region fault.

On a fault the block records the PC of the offending instruction and a cause code, and raises a trap request with a fixed handler address. It keeps the trap pending until the core pulses an acknowledge. On a region fault the block also raises a combinational fetch-suppress output in the same cycle, so the core can skip loading the instruction register.

The step codes are 1 fetch, 2 decode, 3 execute, 4 memory/write-back and 5 load write-back. Because the PC has already moved past the instruction by the execute step, the recorded PC for an illegal opcode is the current PC minus 4.

Top module: `mc_exc_detect`

## Requirements
- R1: After a synchronous active-high reset, trap_req is 0, trap_cause is 2'b00, trap_epc is 0 and trap_vector is 0.
- R2: With step_vld high and step_code 3, the opcodes 6'b000000, 6'b100011, 6'b101011, 6'b000100 and 6'b000010 raise no trap.
- R3: With step_vld high and step_code 3, any other opcode sets trap_req one clock later, with trap_cause 2'b01 and trap_epc equal to cur_pc minus 4.
- R4: The opcode is ignored when step_code is not 3 or step_vld is low.
- R5: With step_vld high and step_code 1, a cur_pc whose value shifted right by 2 is 16 or more sets trap_req one clock later, with trap_cause 2'b10 and trap_epc equal to cur_pc. A smaller word index raises no trap.
- R6: fetch_block is high in the same cycle as a region fault condition (step_vld high, step_code 1, word index 16 or more), and low otherwise.
- R7: The region condition is ignored when step_code is not 1 or step_vld is low.
- R8: While trap_req is high and trap_ack is low, trap_req stays high, trap_cause and trap_epc stay unchanged, and trap_vector equals the handler address 0x00000000.
- R9: A fault that occurs while a trap is pending does not change trap_cause or trap_epc.
- R10: trap_ack high while trap_req is high clears trap_req one clock later. trap_ack while no trap is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_code | input | 3 | Core control step: 1 fetch, 2 decode, 3 execute, 4 memory, 5 load write-back |
| step_vld | input | 1 | Qualifies step_code, cur_pc and ir_opcode this cycle |
| cur_pc | input | 32 | Current program counter (byte address) |
| ir_opcode | input | 6 | Top six bits of the instruction register |
| trap_ack | input | 1 | Core acknowledge that releases a pending trap |
| trap_req | output | 1 | Trap request, held until acknowledged |
| trap_cause | output | 2 | 2'b01 illegal opcode, 2'b10 fetch in data region |
| trap_epc | output | 32 | PC of the faulting instruction |
| trap_vector | output | 32 | Handler address while a trap is pending, else 0 |
| fetch_block | output | 1 | Suppresses the current fetch on a region fault |

## Verification
The assertions assume that the core presents one step code per cycle, so both fault conditions are never true together. They also assume that the acknowledge arrives only from a core that has seen the request. The stimulus drives a single step per transaction on the falling edge and releases step_vld between transactions. It also clears any pending trap with an acknowledge before the next fault sweep point, except where it injects a fault on purpose while a trap is pending.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
   localparam int STEP_W  = 3;
   localparam int CAUSE_W = 2;

   typedef enum logic [STEP_W-1:0] {
      STEP_IDLE   = 3'd0,
      STEP_FETCH  = 3'd1,
      STEP_DECODE = 3'd2,
      STEP_EXEC   = 3'd3,
      STEP_MEM    = 3'd4,
      STEP_LDWB   = 3'd5
   } step_e;

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_NONE   = 2'b00,
      CAUSE_OPC    = 2'b01,
      CAUSE_REGION = 2'b10
   } cause_e;
endpackage

// File: rtl/exc_opc_check.sv
`timescale 1ns/1ps
module exc_opc_check #(
   parameter int OPC_W   = 6,
   parameter int NUM_OPC = 5,
   parameter logic [NUM_OPC*OPC_W-1:0] OPC_LIST = {6'b000000, 6'b100011, 6'b101011, 6'b000100, 6'b000010}
) (
   input  logic [exc_pkg::STEP_W-1:0] step_code,
   input  logic                       step_vld,
   input  logic [OPC_W-1:0]           ir_opcode,
   output logic                       opc_hit
);
   import exc_pkg::*;

   logic [NUM_OPC-1:0] match_vec;

   if (NUM_OPC < 1) begin : g_bad_list
      $error("exc_opc_check: NUM_OPC must be at least 1");
   end

   for (genvar gi = 0; gi < NUM_OPC; gi++) begin : g_match
      assign match_vec[gi] = (ir_opcode == OPC_LIST[gi*OPC_W +: OPC_W]);
   end

   assign opc_hit = step_vld && (step_code == STEP_EXEC) && !(|match_vec);
endmodule

// File: rtl/exc_region_check.sv
`timescale 1ns/1ps
module exc_region_check #(
   parameter int PC_W           = 32,
   parameter int WORD_LSB       = 2,
   parameter int MEM_WORDS      = 32,
   parameter int DATA_BASE_WORD = 16
) (
   input  logic [exc_pkg::STEP_W-1:0] step_code,
   input  logic                       step_vld,
   input  logic [PC_W-1:0]            cur_pc,
   output logic                       region_hit
);
   import exc_pkg::*;

   localparam logic [PC_W-1:0] BASE_IDX = PC_W'(DATA_BASE_WORD);

   logic [PC_W-1:0] word_idx;

   if (DATA_BASE_WORD <= 0 || DATA_BASE_WORD >= MEM_WORDS) begin : g_bad_base
      $error("exc_region_check: DATA_BASE_WORD must lie inside the memory");
   end
   if (WORD_LSB >= PC_W) begin : g_bad_lsb
      $error("exc_region_check: WORD_LSB too large");
   end

   assign word_idx   = cur_pc >> WORD_LSB;
   assign region_hit = step_vld && (step_code == STEP_FETCH) && (word_idx >= BASE_IDX);
endmodule

// File: rtl/exc_capture.sv
`timescale 1ns/1ps
module exc_capture #(
   parameter int PC_W      = 32,
   parameter int PC_STEP   = 4,
   parameter bit REWIND_EN = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        region_hit,
   input  logic                        opc_hit,
   input  logic [PC_W-1:0]             cur_pc,
   input  logic                        trap_ack,
   output logic                        trap_req,
   output logic [exc_pkg::CAUSE_W-1:0] trap_cause,
   output logic [PC_W-1:0]             trap_epc
);
   import exc_pkg::*;

   logic [PC_W-1:0] opc_epc;
   logic            req_q;
   cause_e          cause_q;
   logic [PC_W-1:0] epc_q;

   if (REWIND_EN) begin : g_rewind
      assign opc_epc = cur_pc - PC_W'(PC_STEP);
   end else begin : g_norewind
      assign opc_epc = cur_pc;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q   <= 1'b0;
         cause_q <= CAUSE_NONE;
         epc_q   <= '0;
      end else if (req_q) begin
         if (trap_ack) req_q <= 1'b0;
      end else if (region_hit) begin
         req_q   <= 1'b1;
         cause_q <= CAUSE_REGION;
         epc_q   <= cur_pc;
      end else if (opc_hit) begin
         req_q   <= 1'b1;
         cause_q <= CAUSE_OPC;
         epc_q   <= opc_epc;
      end
   end

   assign trap_req   = req_q;
   assign trap_cause = cause_q;
   assign trap_epc   = epc_q;

   p_region_take_r5: assert property (@(posedge clk) disable iff (rst)
      (!trap_req && region_hit) |=> (trap_req && trap_cause == CAUSE_REGION && trap_epc == $past(cur_pc)));

   p_opc_take_r3: assert property (@(posedge clk) disable iff (rst)
      (!trap_req && opc_hit && !region_hit) |=> (trap_req && trap_cause == CAUSE_OPC));

   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (trap_req && !trap_ack) |=> (trap_req && $stable(trap_cause) && $stable(trap_epc)));

   p_ack_clear_r10: assert property (@(posedge clk) disable iff (rst)
      (trap_req && trap_ack) |=> !trap_req);

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      (!trap_req && !region_hit && !opc_hit) |=> !trap_req);

   p_cause_legal_r9: assert property (@(posedge clk) disable iff (rst)
      trap_req |-> (trap_cause == CAUSE_OPC || trap_cause == CAUSE_REGION));
endmodule

// File: rtl/mc_exc_detect.sv
`timescale 1ns/1ps
module mc_exc_detect #(
   parameter int PC_W           = 32,
   parameter int OPC_W          = 6,
   parameter int WORD_LSB       = 2,
   parameter int MEM_WORDS      = 32,
   parameter int DATA_BASE_WORD = 16,
   parameter int PC_STEP        = 4,
   parameter logic [PC_W-1:0] HANDLER_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        step_code,
   input  logic              step_vld,
   input  logic [PC_W-1:0]   cur_pc,
   input  logic [OPC_W-1:0]  ir_opcode,
   input  logic              trap_ack,
   output logic              trap_req,
   output logic [1:0]        trap_cause,
   output logic [PC_W-1:0]   trap_epc,
   output logic [PC_W-1:0]   trap_vector,
   output logic              fetch_block
);
   import exc_pkg::*;

   localparam int NUM_OPC = 5;
   localparam logic [NUM_OPC*OPC_W-1:0] OPC_LIST =
      {OPC_W'(6'b000000), OPC_W'(6'b100011), OPC_W'(6'b101011), OPC_W'(6'b000100), OPC_W'(6'b000010)};

   if (OPC_W < 6) begin : g_bad_opc
      $error("mc_exc_detect: OPC_W must hold a 6-bit opcode");
   end
   if (PC_STEP != (1 << WORD_LSB)) begin : g_bad_step
      $error("mc_exc_detect: PC_STEP must equal one word");
   end

   logic region_hit;
   logic opc_hit;

   exc_region_check #(
      .PC_W(PC_W), .WORD_LSB(WORD_LSB), .MEM_WORDS(MEM_WORDS), .DATA_BASE_WORD(DATA_BASE_WORD)
   ) i_region (
      .step_code(step_code), .step_vld(step_vld), .cur_pc(cur_pc), .region_hit(region_hit)
   );

   exc_opc_check #(
      .OPC_W(OPC_W), .NUM_OPC(NUM_OPC), .OPC_LIST(OPC_LIST)
   ) i_opc (
      .step_code(step_code), .step_vld(step_vld), .ir_opcode(ir_opcode), .opc_hit(opc_hit)
   );

   exc_capture #(
      .PC_W(PC_W), .PC_STEP(PC_STEP), .REWIND_EN(1'b1)
   ) i_cap (
      .clk(clk), .rst(rst), .region_hit(region_hit), .opc_hit(opc_hit), .cur_pc(cur_pc),
      .trap_ack(trap_ack), .trap_req(trap_req), .trap_cause(trap_cause), .trap_epc(trap_epc)
   );

   assign fetch_block = region_hit;
   assign trap_vector = trap_req ? HANDLER_ADDR : '0;

   p_block_only_fetch_r7: assert property (@(posedge clk) disable iff (rst)
      fetch_block |-> (step_vld && step_code == 3'd1));

   p_opc_epc_r3: assert property (@(posedge clk) disable iff (rst)
      (!trap_req && step_vld && step_code == 3'd3 && opc_hit) |=> (trap_epc == $past(cur_pc) - PC_W'(PC_STEP)));

   p_vector_r8: assert property (@(posedge clk) disable iff (rst)
      trap_req |-> (trap_vector == HANDLER_ADDR));

   p_no_opc_off_exec_r4: assert property (@(posedge clk) disable iff (rst)
      (!trap_req && !(step_vld && (step_code == 3'd1 || step_code == 3'd3))) |=> !trap_req);
endmodule

// File: tb/test_mc_exc_detect.sv
`timescale 1ns/1ps
module test_mc_exc_detect;
   logic        clk = 1'b0;
   logic        rst;
   logic [2:0]  step_code;
   logic        step_vld;
   logic [31:0] cur_pc;
   logic [5:0]  ir_opcode;
   logic        trap_ack;
   logic        trap_req;
   logic [1:0]  trap_cause;
   logic [31:0] trap_epc;
   logic [31:0] trap_vector;
   logic        fetch_block;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic        m_req;
   logic [1:0]  m_cause;
   logic [31:0] m_epc;

   always #4 clk = ~clk;

   mc_exc_detect i_mc_exc_detect (
      .clk(clk), .rst(rst), .step_code(step_code), .step_vld(step_vld), .cur_pc(cur_pc),
      .ir_opcode(ir_opcode), .trap_ack(trap_ack), .trap_req(trap_req), .trap_cause(trap_cause),
      .trap_epc(trap_epc), .trap_vector(trap_vector), .fetch_block(fetch_block)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit supported(input logic [5:0] op);
      return op == 6'b000000 || op == 6'b100011 || op == 6'b101011 ||
             op == 6'b000100 || op == 6'b000010;
   endfunction

   task automatic check_state(input string tag);
      chk({tag, " trap_req"},    {31'd0, trap_req}, {31'd0, m_req});
      chk({tag, " trap_cause"},  {30'd0, trap_cause}, {30'd0, m_cause});
      chk({tag, " trap_epc"},    trap_epc, m_epc);
      chk({tag, " trap_vector R8"}, trap_vector, 32'h0);
   endtask

   // one transaction: drive on falling edge, check fetch_block, then state after the rising edge
   task automatic apply(input string tag, input logic [2:0] st, input logic vld,
                        input logic [31:0] pc, input logic [5:0] op);
      bit reg_cond, opc_cond;
      @(negedge clk);
      step_code = st; step_vld = vld; cur_pc = pc; ir_opcode = op; trap_ack = 1'b0;
      #1;
      reg_cond = vld && st == 3'd1 && (pc >> 2) >= 32'd16;
      opc_cond = vld && st == 3'd3 && !supported(op);
      chk({tag, " fetch_block R6"}, {31'd0, fetch_block}, {31'd0, reg_cond});
      if (!m_req) begin
         if (reg_cond) begin m_req = 1; m_cause = 2'b10; m_epc = pc; end
         else if (opc_cond) begin m_req = 1; m_cause = 2'b01; m_epc = pc - 32'd4; end
      end
      @(posedge clk); #1;
      check_state(tag);
      step_vld = 1'b0;
   endtask

   task automatic ack(input string tag);
      @(negedge clk);
      step_vld = 1'b0; trap_ack = 1'b1;
      @(posedge clk); #1;
      m_req = 0;
      check_state(tag);
      trap_ack = 1'b0;
   endtask

   initial begin
      rst = 1'b1; step_code = 3'd0; step_vld = 1'b0; cur_pc = '0; ir_opcode = '0; trap_ack = 1'b0;
      m_req = 0; m_cause = 2'b00; m_epc = '0;
      repeat (3) @(posedge clk);
      #1;
      check_state("R1 reset");
      @(negedge clk); rst = 1'b0;

      // R2 / R3: every opcode at the execute step
      for (int op = 0; op < 64; op++) begin
         logic [31:0] pc;
         pc = 32'((op % 15) * 4 + 4);
         apply(supported(6'(op)) ? "R2 legal opcode" : "R3 illegal opcode", 3'd3, 1'b1, pc, 6'(op));
         if (m_req) begin
            // R9: a further region fault and opcode fault while pending are ignored
            apply("R9 pending region", 3'd1, 1'b1, 32'h0000_0080, 6'd0);
            apply("R9 pending opcode", 3'd3, 1'b1, 32'h0000_0010, 6'h3F);
            apply("R8 hold idle", 3'd0, 1'b0, 32'h0, 6'd0);
            ack("R10 ack clears");
         end
      end

      // R4: illegal opcode at other steps or with valid low
      for (int st = 0; st < 8; st++) begin
         if (st != 3) apply("R4 opcode off-exec", 3'(st), 1'b1, 32'h0000_0008, 6'h3F);
      end
      apply("R4 opcode valid low", 3'd3, 1'b0, 32'h0000_0008, 6'h3F);

      // R5 / R6: sweep fetch addresses across the region boundary, including unaligned bytes
      for (int w = 0; w < 48; w++) begin
         apply("R5 fetch sweep", 3'd1, 1'b1, 32'(w * 4 + (w % 4)), 6'd0);
         if (m_req) ack("R10 ack after region");
      end
      apply("R5 top address", 3'd1, 1'b1, 32'hFFFF_FFFC, 6'd0);
      if (m_req) ack("R10 ack after top");

      // R7: data-region PC at other steps or with valid low
      for (int st = 0; st < 8; st++) begin
         if (st != 1) apply("R7 region off-fetch", 3'(st), 1'b1, 32'h0000_0040, 6'd0);
      end
      apply("R7 region valid low", 3'd1, 1'b0, 32'h0000_0040, 6'd0);

      // R10: acknowledge while idle has no effect
      ack("R10 ack idle");
      apply("R10 after idle ack", 3'd2, 1'b1, 32'h0, 6'd0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule